// File: doc/BRIEF.md
# Time-Shared Four-Read Two-Write Register Array

This block is a synchronous array of 64 words of 72 bits. It offers four read ports and two write ports to the system clock domain. Storage is a single core with two read ports and one write port. That core runs on a second clock, `clk2x`, at twice the system rate and phase-aligned with it. A two-state phase machine splits each system cycle into two halves. In state PH_A, the half that starts at the `clk` edge, the core serves read ports 0 and 1 and write port 0. In state PH_B, the half that ends at the next `clk` edge, it serves read ports 2 and 3 and write port 1. The PH_A to PH_B transition happens at the mid-cycle `clk2x` edge, and PH_B to PH_A happens at the edge shared with `clk`. Reset forces the machine to PH_A.

All enables, addresses and write data are captured in input registers at the `clk` edge. The core is accessed in the following cycle. Read results pass through a `clk` output register, so read data appears two cycles after the request. A write lands by the end of the access cycle, so any read presented in the next cycle returns the new word. The PH_A read results are held in a `clk2x` register at mid-cycle and realigned with the PH_B results at the `clk` output register.

With `DOUBLE_RATE` cleared, the same wrapper drives the core directly from `clk`. Only read ports 0 and 1 and write port 0 are active in that build, and the other read outputs stay at zero. A read and a write to the same address presented in the same cycle return an undefined value. Reset is applied while the ports are idle.

Top module: `mpr_dual_array`

## Requirements
- R1: While reset is high, all captured enables are cleared and every read output is zero. A write presented during reset does not change the array, and the first cycles after reset show zero on every read output.
- R2: A read request presented in cycle n shows the addressed word on the same port's output from cycle n+2 onward.
- R3: A write presented in cycle n, on either write port, is returned by a read to that address presented in cycle n+1.
- R4: When both write ports target the same address in one cycle, the word stored is the one from write port 1.
- R5: All four read ports may read four different addresses in one cycle, and each returns its own word.
- R6: Two writes to different addresses in one cycle both land.
- R7: A read port whose enable was low holds its previous output value.
- R8: The core phase alternates PH_A, PH_B on every `clk2x` edge and is in PH_B at every `clk` edge. Words written through both write ports in one cycle are then readable from both port groups.
- R9: A write port with its enable low leaves the array unchanged, whatever its address and data.
- R10: All 72 data bits are stored and returned intact, including all-ones, alternating and end-bit patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clk2x | input | 1 | Double-rate clock, rising with every `clk` rise and once mid-cycle |
| reset | input | 1 | Synchronous active-high reset |
| rd0_en | input | 1 | Read port 0 request |
| rd0_addr | input | 6 | Read port 0 word address |
| rd0_q | output | 72 | Read port 0 data |
| rd1_en | input | 1 | Read port 1 request |
| rd1_addr | input | 6 | Read port 1 word address |
| rd1_q | output | 72 | Read port 1 data |
| rd2_en | input | 1 | Read port 2 request |
| rd2_addr | input | 6 | Read port 2 word address |
| rd2_q | output | 72 | Read port 2 data |
| rd3_en | input | 1 | Read port 3 request |
| rd3_addr | input | 6 | Read port 3 word address |
| rd3_q | output | 72 | Read port 3 data |
| wr0_en | input | 1 | Write port 0 request |
| wr0_addr | input | 6 | Write port 0 word address |
| wr0_d | input | 72 | Write port 0 data |
| wr1_en | input | 1 | Write port 1 request (wins on a shared address) |
| wr1_addr | input | 6 | Write port 1 word address |
| wr1_d | input | 72 | Write port 1 data |

## Verification
Some properties are checked on every cycle:
- the strict PH_A/PH_B alternation on `clk2x`, and its alignment to PH_B at each `clk` edge;
- the clearing of captured enables and outputs after reset;
- the rule that an idle read port keeps its output unchanged.

Other behaviours need stored data and can only be shown by the bench's scenarios:
- the two-cycle read latency;
- write-to-read visibility in the next cycle;
- write port 1 winning on a shared address;
- both halves of a cycle writing distinct words;
- writes presented during reset or with the enable low being dropped.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    // Phase of the double-rate core inside one system cycle
    typedef enum logic {
        PH_A = 1'b0,   // first half: read ports 0,1 and write port 0
        PH_B = 1'b1    // second half: read ports 2,3 and write port 1
    } half_e;

    localparam int NUM_RD  = 4;
    localparam int NUM_WR  = 2;
    localparam int CORE_RD = 2;
endpackage

// File: rtl/mpr_capture.sv
module mpr_capture #(
    parameter int NRP = 4,
    parameter int NWP = 2,
    parameter int AW  = 6,
    parameter int DW  = 72
) (
    input  logic                     clk,
    input  logic                     reset,
    input  logic [NRP-1:0]           ren_i,
    input  logic [NRP-1:0][AW-1:0]   raddr_i,
    input  logic [NWP-1:0]           wen_i,
    input  logic [NWP-1:0][AW-1:0]   waddr_i,
    input  logic [NWP-1:0][DW-1:0]   wdata_i,
    output logic [NRP-1:0]           ren_q,
    output logic [NRP-1:0][AW-1:0]   raddr_q,
    output logic [NWP-1:0]           wen_q,
    output logic [NWP-1:0][AW-1:0]   waddr_q,
    output logic [NWP-1:0][DW-1:0]   wdata_q
);
    // Enables are the only captured state that reset touches
    always_ff @(posedge clk) begin
        if (reset) begin
            ren_q <= '0;
            wen_q <= '0;
        end else begin
            ren_q <= ren_i;
            wen_q <= wen_i;
        end
    end

    always_ff @(posedge clk) begin
        raddr_q <= raddr_i;
        waddr_q <= waddr_i;
        wdata_q <= wdata_i;
    end
endmodule

// File: rtl/mpr_core.sv
module mpr_core #(
    parameter int WORDS = 64,
    parameter int AW    = 6,
    parameter int DW    = 72,
    parameter int NR    = 2
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [DW-1:0]          wdata,
    input  logic [NR-1:0][AW-1:0]  raddr,
    output logic [NR-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read ports; the caller registers the results
    for (genvar r = 0; r < NR; r++) begin : g_rd
        assign rdata[r] = mem[raddr[r]];
    end
endmodule

// File: rtl/mpr_sched.sv
module mpr_sched
    import mpr_pkg::*;
#(
    parameter bit DOUBLE_RATE = 1'b1,
    parameter int AW          = 6,
    parameter int DW          = 72
) (
    input  logic                          clk2x,
    input  logic                          reset,
    input  logic [NUM_RD-1:0][AW-1:0]     raddr_q,
    input  logic [NUM_WR-1:0]             wen_q,
    input  logic [NUM_WR-1:0][AW-1:0]     waddr_q,
    input  logic [NUM_WR-1:0][DW-1:0]     wdata_q,
    output logic                          core_we,
    output logic [AW-1:0]                 core_waddr,
    output logic [DW-1:0]                 core_wdata,
    output logic [CORE_RD-1:0][AW-1:0]    core_raddr,
    input  logic [CORE_RD-1:0][DW-1:0]    core_rdata,
    output logic [NUM_RD-1:0][DW-1:0]     res,
    output half_e                         phase
);
    if (DOUBLE_RATE) begin : g_dbl
        half_e state, nxt;
        logic [CORE_RD-1:0][DW-1:0] hold_a;

        // State register, clk2x domain
        always_ff @(posedge clk2x) begin
            if (reset) begin
                state <= PH_A;
            end else begin
                state <= nxt;
            end
        end

        // Next state and the core port steering for each half
        always_comb begin
            nxt        = state;
            core_we    = 1'b0;
            core_waddr = '0;
            core_wdata = '0;
            core_raddr = '0;
            unique case (state)
                PH_A: begin
                    nxt           = PH_B;
                    core_we       = wen_q[0];
                    core_waddr    = waddr_q[0];
                    core_wdata    = wdata_q[0];
                    core_raddr[0] = raddr_q[0];
                    core_raddr[1] = raddr_q[1];
                end
                PH_B: begin
                    nxt           = PH_A;
                    core_we       = wen_q[1];
                    core_waddr    = waddr_q[1];
                    core_wdata    = wdata_q[1];
                    core_raddr[0] = raddr_q[2];
                    core_raddr[1] = raddr_q[3];
                end
            endcase
        end

        // First-half results are parked at mid-cycle for realignment
        always_ff @(posedge clk2x) begin
            if (state == PH_A) begin
                hold_a <= core_rdata;
            end
        end

        assign res[0] = hold_a[0];
        assign res[1] = hold_a[1];
        assign res[2] = core_rdata[0];
        assign res[3] = core_rdata[1];
        assign phase  = state;
    end else begin : g_sgl
        assign core_we       = wen_q[0];
        assign core_waddr    = waddr_q[0];
        assign core_wdata    = wdata_q[0];
        assign core_raddr[0] = raddr_q[0];
        assign core_raddr[1] = raddr_q[1];
        assign res[0]        = core_rdata[0];
        assign res[1]        = core_rdata[1];
        assign res[2]        = '0;
        assign res[3]        = '0;
        assign phase         = PH_A;
    end
endmodule

// File: rtl/mpr_outreg.sv
module mpr_outreg #(
    parameter int NRP = 4,
    parameter int DW  = 72
) (
    input  logic                    clk,
    input  logic                    reset,
    input  logic [NRP-1:0]          en,
    input  logic [NRP-1:0][DW-1:0]  d,
    output logic [NRP-1:0][DW-1:0]  q
);
    for (genvar p = 0; p < NRP; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (reset) begin
                q[p] <= '0;
            end else if (en[p]) begin
                q[p] <= d[p];
            end
        end
    end
endmodule

// File: rtl/mpr_dual_array.sv
module mpr_dual_array
    import mpr_pkg::*;
#(
    parameter bit DOUBLE_RATE = 1'b1,
    parameter int WORDS       = 64,
    parameter int WIDTH       = 72,
    localparam int AW         = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             clk2x,
    input  logic             reset,
    input  logic             rd0_en,
    input  logic [AW-1:0]    rd0_addr,
    output logic [WIDTH-1:0] rd0_q,
    input  logic             rd1_en,
    input  logic [AW-1:0]    rd1_addr,
    output logic [WIDTH-1:0] rd1_q,
    input  logic             rd2_en,
    input  logic [AW-1:0]    rd2_addr,
    output logic [WIDTH-1:0] rd2_q,
    input  logic             rd3_en,
    input  logic [AW-1:0]    rd3_addr,
    output logic [WIDTH-1:0] rd3_q,
    input  logic             wr0_en,
    input  logic [AW-1:0]    wr0_addr,
    input  logic [WIDTH-1:0] wr0_d,
    input  logic             wr1_en,
    input  logic [AW-1:0]    wr1_addr,
    input  logic [WIDTH-1:0] wr1_d
);
    logic [NUM_RD-1:0]              ren_in, cap_ren, eff_ren;
    logic [NUM_RD-1:0][AW-1:0]      raddr_in, cap_raddr;
    logic [NUM_WR-1:0]              wen_in, cap_wen;
    logic [NUM_WR-1:0][AW-1:0]      waddr_in, cap_waddr;
    logic [NUM_WR-1:0][WIDTH-1:0]   wdata_in, cap_wdata;
    logic [NUM_RD-1:0][WIDTH-1:0]   res, rq;
    logic                           core_clk, core_we;
    logic [AW-1:0]                  core_waddr;
    logic [WIDTH-1:0]               core_wdata;
    logic [CORE_RD-1:0][AW-1:0]     core_raddr;
    logic [CORE_RD-1:0][WIDTH-1:0]  core_rdata;
    half_e                          phase;
    logic                           in_b;

    assign ren_in   = {rd3_en, rd2_en, rd1_en, rd0_en};
    assign raddr_in = {rd3_addr, rd2_addr, rd1_addr, rd0_addr};
    assign wen_in   = {wr1_en, wr0_en};
    assign waddr_in = {wr1_addr, wr0_addr};
    assign wdata_in = {wr1_d, wr0_d};

    if (DOUBLE_RATE) begin : g_clk_dbl
        assign core_clk = clk2x;
        assign eff_ren  = cap_ren;
    end else begin : g_clk_sgl
        assign core_clk = clk;
        assign eff_ren  = {2'b00, cap_ren[1:0]};
    end

    mpr_capture #(.NRP(NUM_RD), .NWP(NUM_WR), .AW(AW), .DW(WIDTH)) u_cap (
        .clk(clk), .reset(reset),
        .ren_i(ren_in), .raddr_i(raddr_in),
        .wen_i(wen_in), .waddr_i(waddr_in), .wdata_i(wdata_in),
        .ren_q(cap_ren), .raddr_q(cap_raddr),
        .wen_q(cap_wen), .waddr_q(cap_waddr), .wdata_q(cap_wdata)
    );

    mpr_sched #(.DOUBLE_RATE(DOUBLE_RATE), .AW(AW), .DW(WIDTH)) u_sched (
        .clk2x(clk2x), .reset(reset),
        .raddr_q(cap_raddr), .wen_q(cap_wen), .waddr_q(cap_waddr),
        .wdata_q(cap_wdata),
        .core_we(core_we), .core_waddr(core_waddr), .core_wdata(core_wdata),
        .core_raddr(core_raddr), .core_rdata(core_rdata),
        .res(res), .phase(phase)
    );

    mpr_core #(.WORDS(WORDS), .AW(AW), .DW(WIDTH), .NR(CORE_RD)) u_core (
        .clk(core_clk), .we(core_we), .waddr(core_waddr), .wdata(core_wdata),
        .raddr(core_raddr), .rdata(core_rdata)
    );

    mpr_outreg #(.NRP(NUM_RD), .DW(WIDTH)) u_out (
        .clk(clk), .reset(reset), .en(eff_ren), .d(res), .q(rq)
    );

    assign in_b  = (phase == PH_B);
    assign rd0_q = rq[0];
    assign rd1_q = rq[1];
    assign rd2_q = rq[2];
    assign rd3_q = rq[3];
endmodule

// File: rtl/mpr_dual_array_chk.sv
module mpr_dual_array_chk #(
    parameter bit DOUBLE_RATE = 1'b1,
    parameter int NRP         = 4,
    parameter int NWP         = 2,
    parameter int DW          = 72
) (
    input logic                    clk,
    input logic                    clk2x,
    input logic                    reset,
    input logic [NRP-1:0]          cap_ren,
    input logic [NWP-1:0]          cap_wen,
    input logic                    second_half,
    input logic [NRP-1:0][DW-1:0]  rd_q
);
    // R1: one cycle after reset, captured enables and outputs are clear
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (reset)
        $past(reset) |-> (cap_ren == '0 && cap_wen == '0 && rd_q == '0));

    // R7: an idle read port keeps its output
    for (genvar i = 0; i < NRP; i++) begin : g_hold
        assert_idle_hold_R7: assert property (@(posedge clk) disable iff (reset)
            !cap_ren[i] |=> $stable(rd_q[i]));
    end

    if (DOUBLE_RATE) begin : g_phase
        // R8: the two halves alternate on every clk2x edge
        assert_a_to_b_R8: assert property (@(posedge clk2x) disable iff (reset)
            !second_half |=> second_half);
        assert_b_to_a_R8: assert property (@(posedge clk2x) disable iff (reset)
            second_half |=> !second_half);
        // R8: every clk edge closes the second half
        assert_clk_align_R8: assert property (@(posedge clk) disable iff (reset)
            second_half);
    end
endmodule

bind mpr_dual_array mpr_dual_array_chk #(
    .DOUBLE_RATE(DOUBLE_RATE), .NRP(4), .NWP(2), .DW(WIDTH)
) u_chk (
    .clk(clk), .clk2x(clk2x), .reset(reset),
    .cap_ren(eff_ren), .cap_wen(cap_wen),
    .second_half(in_b), .rd_q(rq)
);

// File: tb/mpr_dual_array_test.sv
`timescale 1ns/1ps
module mpr_dual_array_test;
    logic        clk, clk2x, reset;
    logic [3:0]  re;
    logic [5:0]  ra [4];
    logic [1:0]  we;
    logic [5:0]  wa [2];
    logic [71:0] wd [2];
    logic [71:0] q0, q1, q2, q3;

    // Staged stimulus for the next cycle
    logic [3:0]  n_re;
    logic [5:0]  n_ra [4];
    logic [1:0]  n_we;
    logic [5:0]  n_wa [2];
    logic [71:0] n_wd [2];

    logic [71:0] model [64];
    logic [71:0] last [4];
    string       idle_tag;

    int          q_due [$];
    int          q_port [$];
    logic [71:0] q_val [$];
    string       q_tag [$];

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    mpr_dual_array uut (
        .clk(clk), .clk2x(clk2x), .reset(reset),
        .rd0_en(re[0]), .rd0_addr(ra[0]), .rd0_q(q0),
        .rd1_en(re[1]), .rd1_addr(ra[1]), .rd1_q(q1),
        .rd2_en(re[2]), .rd2_addr(ra[2]), .rd2_q(q2),
        .rd3_en(re[3]), .rd3_addr(ra[3]), .rd3_q(q3),
        .wr0_en(we[0]), .wr0_addr(wa[0]), .wr0_d(wd[0]),
        .wr1_en(we[1]), .wr1_addr(wa[1]), .wr1_d(wd[1])
    );

    // 100 MHz clk, 200 MHz clk2x sharing the rising edge
    initial begin
        clk = 0;
        clk2x = 0;
        forever begin
            clk2x = 1; clk = 1;
            #2.5 clk2x = 0;
            #2.5 clk2x = 1; clk = 0;
            #2.5 clk2x = 0;
            #2.5;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [71:0] word_of(int a);
        return {8'(a) ^ 8'h3C, 64'hFEDC_BA98_7654_3210 + 64'(a) * 64'h0101_0101_0101_0101};
    endfunction

    function automatic logic [71:0] port_out(int p);
        case (p)
            0: return q0;
            1: return q1;
            2: return q2;
            default: return q3;
        endcase
    endfunction

    task automatic clear_next();
        n_re = '0;
        n_we = '0;
        for (int i = 0; i < 4; i++) n_ra[i] = '0;
        for (int i = 0; i < 2; i++) begin
            n_wa[i] = '0;
            n_wd[i] = '0;
        end
    endtask

    task automatic set_read(int p, int a);
        n_re[p] = 1'b1;
        n_ra[p] = 6'(a);
    endtask

    task automatic set_write(int w, int a, logic [71:0] d);
        n_we[w] = 1'b1;
        n_wa[w] = 6'(a);
        n_wd[w] = d;
    endtask

    // Driver: presents one cycle of stimulus and queues what the outputs must show
    task automatic step(string tag);
        @(posedge clk);
        #1;
        re = n_re;
        we = n_we;
        for (int i = 0; i < 4; i++) ra[i] = n_ra[i];
        for (int i = 0; i < 2; i++) begin
            wa[i] = n_wa[i];
            wd[i] = n_wd[i];
        end
        for (int p = 0; p < 4; p++) begin
            q_due.push_back(cyc + 2);
            q_port.push_back(p);
            if (re[p]) begin
                last[p] = model[ra[p]];
                q_tag.push_back(tag);
            end else begin
                q_tag.push_back(idle_tag);
            end
            q_val.push_back(last[p]);
        end
        // port 1 applied after port 0: it wins on a shared address
        if (we[0]) model[wa[0]] = wd[0];
        if (we[1]) model[wa[1]] = wd[1];
        idle_tag = "R7";
        clear_next();
    endtask

    task automatic drain();
        while (q_due.size() != 0) @(posedge clk);
        @(posedge clk);
    endtask

    // Reset with writes and reads requested that must all be dropped
    task automatic do_reset(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            reset = 1'b1;
            re = 4'hF;
            for (int i = 0; i < 4; i++) ra[i] = 6'd50;
            we = 2'b11;
            wa[0] = 6'd50;
            wd[0] = 72'hDE_AD00_BEEF_0000_1111;
            wa[1] = 6'd51;
            wd[1] = 72'h12_3456_789A_BCDE_F012;
        end
        @(posedge clk);
        #1;
        reset = 1'b0;
        re = '0;
        we = '0;
        for (int i = 0; i < 4; i++) last[i] = '0;
        idle_tag = "R1";
    endtask

    // Monitor: compares each queued item in the cycle it falls due
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (q_due.size() != 0 && q_due[0] <= cyc) begin
                int p;
                logic [71:0] exp, act;
                string tg;
                p = q_port.pop_front();
                exp = q_val.pop_front();
                tg = q_tag.pop_front();
                void'(q_due.pop_front());
                act = port_out(p);
                checks++;
                if (act !== exp) begin
                    failures++;
                    $display("FAIL %s port %0d: actual %h expected %h", tg, p, act, exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        reset = 1'b1;
        re = '0;
        we = '0;
        for (int i = 0; i < 4; i++) ra[i] = '0;
        for (int i = 0; i < 2; i++) begin
            wa[i] = '0;
            wd[i] = '0;
        end
        for (int i = 0; i < 4; i++) last[i] = '0;
        idle_tag = "R1";
        clear_next();
        do_reset(3);

        // R1: outputs are zero after reset
        step("R1");

        // R6: fill the array two words per cycle through both write ports
        for (int a = 0; a < 64; a += 2) begin
            set_write(0, a, word_of(a));
            set_write(1, a + 1, word_of(a + 1));
            step("R6");
        end

        // R2: single reads rotating over the ports
        for (int k = 0; k < 8; k++) begin
            set_read(k % 4, (k * 7 + 1) % 64);
            step("R2");
        end

        // R5: four different addresses on four ports at once
        for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < 4; p++) set_read(p, (k * 16 + p * 5 + 3) % 64);
            step("R5");
        end

        // R3: write then read in the next cycle, both write ports
        set_write(0, 10, 72'hA1_0000_1111_2222_3333);
        step("R3");
        set_read(3, 10);
        set_read(0, 10);
        step("R3");
        set_write(1, 11, 72'hB2_4444_5555_6666_7777);
        step("R3");
        set_read(1, 11);
        set_read(2, 11);
        step("R3");

        // R4: both write ports on one address
        set_write(0, 20, 72'h0F_0F0F_0F0F_0F0F_0F0F);
        set_write(1, 20, 72'hF0_F0F0_F0F0_F0F0_F0F0);
        step("R4");
        set_read(0, 20);
        set_read(3, 20);
        step("R4");

        // R8: both halves write; both port groups read both words
        set_write(0, 30, 72'h30_3030_3030_3030_3030);
        set_write(1, 31, 72'h31_3131_3131_3131_3131);
        step("R8");
        set_read(2, 30);
        set_read(0, 31);
        set_read(1, 30);
        set_read(3, 31);
        step("R8");

        // R10: full-width patterns
        set_write(0, 40, {72{1'b1}});
        set_write(1, 41, {18{4'h5}});
        step("R10");
        set_write(0, 42, {18{4'hA}});
        set_write(1, 43, {1'b1, 70'd0, 1'b1});
        step("R10");
        for (int p = 0; p < 4; p++) set_read(p, 40 + p);
        step("R10");

        // R9: address and data presented with the enable low
        n_wa[0] = 6'd10;
        n_wd[0] = 72'hEE_EEEE_EEEE_EEEE_EEEE;
        n_wa[1] = 6'd11;
        n_wd[1] = 72'hDD_DDDD_DDDD_DDDD_DDDD;
        step("R9");
        set_read(1, 10);
        set_read(2, 11);
        step("R9");

        // R7: idle cycles keep the last outputs
        step("R7");
        step("R7");

        // R1: reset with writes pending, then confirm the words survived
        drain();
        do_reset(3);
        step("R1");
        step("R1");
        set_read(2, 50);
        set_read(1, 51);
        step("R1");
        step("R7");

        drain();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule